// File: doc/BRIEF.md
# UART Receiver with Break Wake-up

This block is an asynchronous serial receiver for 8-bit characters with one start bit, no parity and one stop bit. It runs from the system clock and from an external tick strobe that pulses sixteen times per bit period. The serial input is passed through a synchronizer. A small register-style interface lets software read the received byte, observe a receive-flag interrupt, read the framing and overrun status and the receive-idle status, and write an arm bit.

Setting the arm bit puts the receiver into a wake-on-activity mode. While the bit is set, character assembly is suspended. The block only watches the line for a falling edge, which raises the receive flag with no byte assembled. The rising edge that ends that low period then clears the arm bit in hardware, and the receiver returns to its normal idle state to wait for the next start bit.

A typical wake-up pulse is a break of all zeros that lasts at least ten bit times. Thirteen bit times is common on single-wire automotive buses. If a character that is not all zeros arrives while the block is armed, only its first low stretch acts as the wake event. The bits after it may then be picked up as a fragmented character.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, `rx_irq`, `wake_arm`, `frame_err` and `overrun` are 0, and `rx_idle` is 1.
- R2: With `wake_arm` low, a frame is received as follows. A low start bit is confirmed at its middle. Then 8 data bits are sampled least-significant bit first, each at mid-bit, followed by a stop bit. When the stop bit is sampled, the byte appears on `rdata` and `rx_irq` goes to 1.
- R3: A one-cycle pulse on `data_rd` clears `rx_irq` on the next clock edge, unless a new event sets the flag in that same cycle.
- R4: `frame_err` is loaded with 1 when the stop bit of an accepted character samples low, and with 0 when it samples high. Between accepted characters it holds its value.
- R5: A character that completes while `rx_irq` is still 1 and no `data_rd` is present sets `overrun` to 1 and is discarded, so `rdata` keeps the earlier byte. A `data_rd` pulse clears `overrun`.
- R6: Writing `arm_wdata` with `arm_wr` high loads `wake_arm`. While `wake_arm` is 1, no character is assembled: `rx_idle` stays 1, and `rdata` and `frame_err` do not change.
- R7: While `wake_arm` is 1, a high-to-low transition on `rxd` sets `rx_irq`. The flag is visible by the second clock edge after the transition has passed the synchronizer. `wake_arm` stays at 1.
- R8: After a wake event, the next low-to-high transition on `rxd` clears `wake_arm` in hardware. Normal reception then resumes with the next start bit.
- R9: Arming while `rxd` is already low does not set `rx_irq`. The rising edge that ends that low period does not clear `wake_arm`. Only a later falling edge counts as a wake event.
- R10: If the wake-up character is not all zeros, its first rising edge disarms the block. A later low bit in that character is then taken as a start bit. For example, the character 0x01 followed by an idle-high line yields the fragment byte 0xC0.
- R11: `rx_idle` is 0 while a character is being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| data_rd | input | 1 | Read strobe for the data register; clears the flag |
| rdata | output | 8 | Last accepted received byte |
| wake_arm | output | 1 | Arm bit for wake-on-activity |
| rx_idle | output | 1 | High when no character is being assembled |
| rx_irq | output | 1 | Receive flag (byte ready or wake event) |
| frame_err | output | 1 | Stop bit of the last accepted character was low |
| overrun | output | 1 | A character was dropped because the flag was unread |

## Verification
The assertions check the following on every cycle:
- an armed receiver stays idle and leaves the data register untouched;
- an armed falling edge raises the flag;
- the rising edge after a wake disarms the block, while a rising edge with no prior wake does not;
- a read clears the flag;
- an unread completion raises the overrun;
- the framing status changes only when a character completes.

Only the bench scenarios can show the following:
- the bit order and mid-bit sampling, which are swept over every byte value;
- the dropped byte on overrun;
- the ordering of arm-while-low, release and a later edge;
- the exact fragment byte that follows a non-zero wake character.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line = chain_q[STAGES-1];
  assign fall = prev_q & ~line;
  assign rise = ~prev_q & line;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_wake_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          fall,
  input  logic          hold,
  output logic          done,
  output logic          stop_ok,
  output logic [DW-1:0] byte_out,
  output logic          idle
);

  localparam int CW = $clog2(OSR);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    done    = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (fall) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == MID_CNT) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (cnt_q == LAST_CNT) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[DW-1:1]};
            if (bit_q == LAST_BIT) state_d = RX_STOP;
            else                   bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (cnt_q == LAST_CNT) begin
            done    = 1'b1;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
    if (hold) begin
      state_d = RX_IDLE;
      done    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign stop_ok  = line;
  assign byte_out = sh_q;
  assign idle     = (state_q == RX_IDLE);

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_wr,
  input  logic          arm_wdata,
  input  logic          data_rd,
  input  logic          fall,
  input  logic          rise,
  input  logic          done,
  input  logic          stop_ok,
  input  logic [DW-1:0] byte_in,
  output logic          arm,
  output logic          woke,
  output logic          flag,
  output logic          ferr,
  output logic          oerr,
  output logic [DW-1:0] rdata
);

  logic          arm_d, woke_d, flag_d, ferr_d, oerr_d;
  logic [DW-1:0] rdata_d;
  logic          wake_evt, accept, drop;

  assign wake_evt = arm & fall;
  assign drop     = done & flag & ~data_rd;
  assign accept   = done & ~drop;

  always_comb begin
    arm_d   = arm;
    woke_d  = woke;
    flag_d  = flag;
    ferr_d  = ferr;
    oerr_d  = oerr;
    rdata_d = rdata;
    if (arm_wr) begin
      arm_d  = arm_wdata;
      woke_d = 1'b0;
    end else if (arm && woke && rise) begin
      arm_d  = 1'b0;
      woke_d = 1'b0;
    end else if (wake_evt) begin
      woke_d = 1'b1;
    end
    if (data_rd) begin
      flag_d = 1'b0;
      oerr_d = 1'b0;
    end
    if (wake_evt || done) flag_d = 1'b1;
    if (drop) oerr_d = 1'b1;
    if (accept) begin
      rdata_d = byte_in;
      ferr_d  = ~stop_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm   <= 1'b0;
      woke  <= 1'b0;
      flag  <= 1'b0;
      ferr  <= 1'b0;
      oerr  <= 1'b0;
      rdata <= '0;
    end else begin
      arm   <= arm_d;
      woke  <= woke_d;
      flag  <= flag_d;
      ferr  <= ferr_d;
      oerr  <= oerr_d;
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          arm_wr,
  input  logic          arm_wdata,
  input  logic          data_rd,
  output logic [DW-1:0] rdata,
  output logic          wake_arm,
  output logic          rx_idle,
  output logic          rx_irq,
  output logic          frame_err,
  output logic          overrun
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          rx_line, rx_fall, rx_rise;
  logic          rx_done, rx_stop_ok, woke;
  logic [DW-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst_n (rst_n_s),
    .din (rxd),
    .line (rx_line),
    .fall (rx_fall),
    .rise (rx_rise)
  );

  uart_rx_core #(.OSR(OSR), .DW(DW)) i_core (
    .clk (clk),
    .rst_n (rst_n_s),
    .tick (baud_tick),
    .line (rx_line),
    .fall (rx_fall),
    .hold (wake_arm),
    .done (rx_done),
    .stop_ok (rx_stop_ok),
    .byte_out (rx_byte),
    .idle (rx_idle)
  );

  uart_rx_regs #(.DW(DW)) i_regs (
    .clk (clk),
    .rst_n (rst_n_s),
    .arm_wr (arm_wr),
    .arm_wdata (arm_wdata),
    .data_rd (data_rd),
    .fall (rx_fall),
    .rise (rx_rise),
    .done (rx_done),
    .stop_ok (rx_stop_ok),
    .byte_in (rx_byte),
    .arm (wake_arm),
    .woke (woke),
    .flag (rx_irq),
    .ferr (frame_err),
    .oerr (overrun),
    .rdata (rdata)
  );

endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fall,
  input logic          rise,
  input logic          done,
  input logic          woke,
  input logic          rd,
  input logic          arm_wr,
  input logic          wake_arm,
  input logic          rx_idle,
  input logic          irq,
  input logic          ferr,
  input logic          oerr,
  input logic [DW-1:0] rdata
);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !done && !(wake_arm && fall) |=> !irq);

  p_unread_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && irq && !rd |=> oerr);

  p_ferr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ferr));

  p_armed_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_arm |=> rx_idle);

  p_armed_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_arm |=> $stable(rdata));

  p_wake_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_arm && fall |=> irq);

  p_end_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_arm && woke && rise && !arm_wr |=> !wake_arm);

  p_no_early_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_arm && !woke && rise && !arm_wr |=> wake_arm);

endmodule

bind uart_rx_wake uart_rx_wake_chk #(.DW(DW)) i_chk (
  .clk (clk),
  .rst_n (rst_n_s),
  .fall (rx_fall),
  .rise (rx_rise),
  .done (rx_done),
  .woke (woke),
  .rd (data_rd),
  .arm_wr (arm_wr),
  .wake_arm (wake_arm),
  .rx_idle (rx_idle),
  .irq (rx_irq),
  .ferr (frame_err),
  .oerr (overrun),
  .rdata (rdata)
);

// File: tb/test_uart_rx_wake.sv
`timescale 1ns/1ps
module test_uart_rx_wake;

  localparam int BT    = 32;
  localparam int LIMIT = 190000;

  logic       clk, rst_n, baud_tick, rxd, arm_wr, arm_wdata, data_rd;
  logic [7:0] rdata;
  logic       wake_arm, rx_idle, rx_irq, frame_err, overrun;
  int         checks, fails, tdiv;
  bit         finished;

  uart_rx_wake i_uart_rx_wake (
    .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick), .rxd (rxd),
    .arm_wr (arm_wr), .arm_wdata (arm_wdata), .data_rd (data_rd),
    .rdata (rdata), .wake_arm (wake_arm), .rx_idle (rx_idle),
    .rx_irq (rx_irq), .frame_err (frame_err), .overrun (overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv + 1) % 2;
    baud_tick <= (tdiv == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
  endtask

  task automatic write_arm(input logic v);
    @(negedge clk) begin arm_wr = 1'b1; arm_wdata = v; end
    @(negedge clk) arm_wr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    rxd = 1'b0;
    idle_cyc(BT);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      idle_cyc(BT);
    end
    rxd = stop;
    idle_cyc(BT);
    rxd = 1'b1;
    idle_cyc(6);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0; tdiv = 0; baud_tick = 0;
    rxd = 1; arm_wr = 0; arm_wdata = 0; data_rd = 0; rst_n = 0;
    idle_cyc(5);
    rst_n = 1;
    idle_cyc(5);
    // R1 reset state
    chk("R1 irq", rx_irq, 0);
    chk("R1 arm", wake_arm, 0);
    chk("R1 idle", rx_idle, 1);
    chk("R1 ferr", frame_err, 0);
    chk("R1 oerr", overrun, 0);

    // R2 / R3 sweep over every byte value
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 1'b1);
      chk("R2 data", rdata, b);
      chk("R2 flag", rx_irq, 1);
      chk("R4 ferr clear", frame_err, 0);
      do_read();
      chk("R3 flag cleared", rx_irq, 0);
    end

    // R4 framing error
    send_frame(8'hA5, 1'b0);
    chk("R4 ferr set", frame_err, 1);
    chk("R4 data", rdata, 8'hA5);
    do_read();
    send_frame(8'h5A, 1'b1);
    chk("R4 ferr reload", frame_err, 0);
    do_read();

    // R5 overrun
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    chk("R5 oerr set", overrun, 1);
    chk("R5 byte dropped", rdata, 8'h11);
    do_read();
    chk("R5 oerr cleared", overrun, 0);
    chk("R5 flag cleared", rx_irq, 0);

    // R6 software write sets and clears arm
    write_arm(1'b1);
    chk("R6 armed", wake_arm, 1);
    write_arm(1'b0);
    chk("R6 disarmed", wake_arm, 0);

    // R7 / R8 break wake-up
    write_arm(1'b1);
    rxd = 1'b0;
    idle_cyc(4);
    chk("R7 wake flag", rx_irq, 1);
    chk("R7 arm held", wake_arm, 1);
    idle_cyc(13 * BT);
    chk("R6 idle while armed", rx_idle, 1);
    chk("R6 data unchanged", rdata, 8'h11);
    chk("R6 ferr unchanged", frame_err, 0);
    rxd = 1'b1;
    idle_cyc(4);
    chk("R8 arm cleared", wake_arm, 0);
    chk("R8 flag kept", rx_irq, 1);
    do_read();
    chk("R3 wake flag cleared", rx_irq, 0);
    send_frame(8'h3C, 1'b1);
    chk("R8 reception resumes", rdata, 8'h3C);
    do_read();

    // R9 arming while the line is low
    rxd = 1'b0;
    idle_cyc(8);
    write_arm(1'b1);
    idle_cyc(8);
    chk("R9 no flag", rx_irq, 0);
    rxd = 1'b1;
    idle_cyc(8);
    chk("R9 arm kept", wake_arm, 1);
    chk("R9 still no flag", rx_irq, 0);
    rxd = 1'b0;
    idle_cyc(4);
    chk("R9 later edge wakes", rx_irq, 1);
    rxd = 1'b1;
    idle_cyc(4);
    chk("R9 disarm after wake", wake_arm, 0);
    do_read();

    // R10 / R11 non-zero wake character 0x01 -> fragment 0xC0
    write_arm(1'b1);
    rxd = 1'b0;
    idle_cyc(8);
    chk("R10 wake flag", rx_irq, 1);
    do_read();
    idle_cyc(BT - 10);
    rxd = 1'b1;
    idle_cyc(8);
    chk("R10 disarmed", wake_arm, 0);
    idle_cyc(BT - 8);
    rxd = 1'b0;
    idle_cyc(BT + BT / 2);
    chk("R11 busy", rx_idle, 0);
    idle_cyc(6 * BT - BT / 2);
    rxd = 1'b1;
    idle_cyc(4 * BT);
    chk("R10 fragment", rdata, 8'hC0);
    chk("R10 flag", rx_irq, 1);
    chk("R10 no overrun", overrun, 0);
    chk("R11 idle again", rx_idle, 1);
    do_read();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule